// File: doc/BRIEF.md
# CSR Atomic Read-and-Set / Read-and-Clear Unit

This block carries out the two bit-manipulating CSR access forms, set-bits and clear-bits, against a small bank of control registers that it owns. Each operation is issued with a one-cycle valid strobe, an operation code, a 12-bit register address, the 5-bit source register index and the 32-bit source operand. In the immediate forms, the 5-bit source index field itself is the operand. One clock edge later the unit presents the register's previous contents for the destination register. It also presents a strobe for the read side effect, a strobe for the whole-register write effect, a per-bit write-effect vector and an illegal-instruction flag. Instruction-word decode and privilege checking are done upstream.

The write is kept or dropped according to the source index field and never according to the operand value. A zero index (x0, or a zero immediate) makes the access a pure read. Such a read is legal even on a read-only register and triggers no write effect. A nonzero index with a zero operand is still a write. It fires the whole-register effect but marks no field.

Register i of the bank sits at address `CSR_BASE + i`. Each register has its own writable-bit mask, its own reset value and a read-only flag, all given by parameters.

Top module: `csr_rmw_unit`

## Requirements
- R1: While `rst_i` is high, every output is zero and each register returns to its reset value. Defaults: reg0=0x12345678, reg1=0x00000000, reg2=0x00000030, reg3=0xA5A50001.
- R2: A legal operation returns the register's previous value, zero-extended, on `rd_o` and pulses `rd_fx_o` on the cycle after the valid strobe. This holds whatever the index and operand are.
- R3: Set forms (op 2'b00 register, 2'b10 immediate) OR the operand into the register, only in the bits its writable mask allows. Default masks: reg0 0xFFFFFFFF, reg1 0xF0F0F0F0, reg2 0x000000FF, reg3 0xFFFFFFFF.
- R4: Clear forms (op 2'b01 register, 2'b11 immediate) clear each register bit whose operand bit is 1, only in writable bits.
- R5: In the immediate forms (op bit 1 set), the operand is the 5-bit index field zero-extended to 32 bits. `rs1_val_i` is ignored.
- R6: A zero index field makes no write. `wr_fx_o` stays 0, `fld_fx_o` stays 0, the register is unchanged, and no illegal flag is raised even for a read-only register.
- R7: A nonzero index with a zero register operand pulses `wr_fx_o`, keeps `fld_fx_o` at zero and leaves the register unchanged.
- R8: On a write, `fld_fx_o` equals the operand ANDed with the register's writable mask.
- R9: A write attempt (nonzero index) to a read-only register (default: reg3 only) raises `ill_o`. It leaves the register unchanged, and all other strobes and `rd_o` are zero.
- R10: An address outside `CSR_BASE..CSR_BASE+NUM_CSR-1` (default base 0x7C0) raises `ill_o`, with `rd_o` and all strobes zero.
- R11: Each operation completes in one cycle. An operation issued on the very next cycle reads the updated value.
- R12: A cycle without the valid strobe yields all strobes, `ill_o` and `rd_o` zero on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| vld_i | input | 1 | Operation valid strobe |
| op_i | input | 2 | bit0: 1 clear / 0 set; bit1: 1 immediate / 0 register |
| addr_i | input | 12 | Register address |
| rs1_idx_i | input | 5 | Source index field, also the immediate |
| rs1_val_i | input | 32 | Source register operand |
| rd_o | output | 32 | Previous register value for the destination |
| rd_fx_o | output | 1 | Read side-effect strobe |
| wr_fx_o | output | 1 | Whole-register write-effect strobe |
| fld_fx_o | output | 32 | Per-bit write-effect strobes |
| ill_o | output | 1 | Illegal-instruction flag |

## Verification
A register holding a wrong value shows up at the next operation addressed to it, since every operation returns the previous contents on `rd_o` one cycle later. A back-to-back read therefore exposes a bad update within two cycles. A mistake in write suppression or legality shows in the same cycle as the result, as a stray or missing write strobe or illegal flag. The random stream mixes zero and nonzero indices and zero operands across all four registers and one address on each side of the bank, so that both faults are hit.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;
  typedef enum logic [1:0] {
    OP_SET  = 2'b00,
    OP_CLR  = 2'b01,
    OP_SETI = 2'b10,
    OP_CLRI = 2'b11
  } rmw_op_e;
endpackage

// File: rtl/csr_rmw_decode.sv
module csr_rmw_decode
  import csr_rmw_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_CSR  = 4,
  parameter int ADDR_W   = 12,
  parameter int IDX_W    = 5,
  parameter int CSR_BASE = 12'h7C0,
  parameter logic [NUM_CSR-1:0] RO_MAP = 4'b1000,
  localparam int SEL_W   = (NUM_CSR > 1) ? $clog2(NUM_CSR) : 1
) (
  input  logic              vld_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [XLEN-1:0]   val_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic [XLEN-1:0]   mask_o,
  output logic              clr_o,
  output logic              rd_ok_o,
  output logic              wr_ok_o,
  output logic              ill_o
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CSR_BASE);
  localparam logic [ADDR_W-1:0] CNT_A  = ADDR_W'(NUM_CSR);

  rmw_op_e             op;
  logic [ADDR_W-1:0]   ofs;
  logic                hit;
  logic                wr_att;
  logic                ro;

  assign op     = rmw_op_e'(op_i);
  assign ofs    = addr_i - BASE_A;
  assign hit    = (addr_i >= BASE_A) && (ofs < CNT_A);
  assign sel_o  = ofs[SEL_W-1:0];
  assign wr_att = (idx_i != '0);
  assign ro     = hit && RO_MAP[sel_o];
  assign clr_o  = (op == OP_CLR) || (op == OP_CLRI);

  always_comb begin
    if (op == OP_SETI || op == OP_CLRI) mask_o = {{(XLEN-IDX_W){1'b0}}, idx_i};
    else                                mask_o = val_i;
  end

  assign ill_o   = vld_i && (!hit || (wr_att && ro));
  assign rd_ok_o = vld_i && !ill_o;
  assign wr_ok_o = rd_ok_o && wr_att;
endmodule

// File: rtl/csr_rmw_bank.sv
module csr_rmw_bank #(
  parameter int XLEN    = 32,
  parameter int NUM_CSR = 4,
  parameter logic [NUM_CSR*XLEN-1:0] WMASK   = {32'hFFFF_FFFF, 32'h0000_00FF, 32'hF0F0_F0F0, 32'hFFFF_FFFF},
  parameter logic [NUM_CSR*XLEN-1:0] RST_VAL = {32'hA5A5_0001, 32'h0000_0030, 32'h0000_0000, 32'h1234_5678},
  localparam int SEL_W  = (NUM_CSR > 1) ? $clog2(NUM_CSR) : 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             we_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [XLEN-1:0]  mask_i,
  output logic [XLEN-1:0]  rd_o,
  output logic [XLEN-1:0]  eff_o
);
  logic [XLEN-1:0] regs [NUM_CSR];
  logic [XLEN-1:0] wms  [NUM_CSR];

  for (genvar g = 0; g < NUM_CSR; g++) begin : g_csr
    assign wms[g] = WMASK[g*XLEN +: XLEN];
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        regs[g] <= RST_VAL[g*XLEN +: XLEN];
      end else if (we_i && (32'(sel_i) == g)) begin
        if (clr_i) regs[g] <= regs[g] & ~(mask_i & wms[g]);
        else       regs[g] <= regs[g] |  (mask_i & wms[g]);
      end
    end
  end

  always_comb begin
    rd_o  = '0;
    eff_o = '0;
    for (int k = 0; k < NUM_CSR; k++) begin
      if (32'(sel_i) == k) begin
        rd_o  = regs[k];
        eff_o = mask_i & wms[k];
      end
    end
  end
endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit #(
  parameter int XLEN     = 32,
  parameter int NUM_CSR  = 4,
  parameter int ADDR_W   = 12,
  parameter int IDX_W    = 5,
  parameter int CSR_BASE = 12'h7C0,
  parameter logic [NUM_CSR-1:0]      RO_MAP  = 4'b1000,
  parameter logic [NUM_CSR*XLEN-1:0] WMASK   = {32'hFFFF_FFFF, 32'h0000_00FF, 32'hF0F0_F0F0, 32'hFFFF_FFFF},
  parameter logic [NUM_CSR*XLEN-1:0] RST_VAL = {32'hA5A5_0001, 32'h0000_0030, 32'h0000_0000, 32'h1234_5678}
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              vld_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [IDX_W-1:0]  rs1_idx_i,
  input  logic [XLEN-1:0]   rs1_val_i,
  output logic [XLEN-1:0]   rd_o,
  output logic              rd_fx_o,
  output logic              wr_fx_o,
  output logic [XLEN-1:0]   fld_fx_o,
  output logic              ill_o
);
  localparam int SEL_W = (NUM_CSR > 1) ? $clog2(NUM_CSR) : 1;

  logic [SEL_W-1:0] sel;
  logic [XLEN-1:0]  mask, cur, eff;
  logic             clr, rd_ok, wr_ok, ill;

  csr_rmw_decode #(
    .XLEN(XLEN), .NUM_CSR(NUM_CSR), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .CSR_BASE(CSR_BASE), .RO_MAP(RO_MAP)
  ) i_decode (
    .vld_i(vld_i), .op_i(op_i), .addr_i(addr_i), .idx_i(rs1_idx_i),
    .val_i(rs1_val_i), .sel_o(sel), .mask_o(mask), .clr_o(clr),
    .rd_ok_o(rd_ok), .wr_ok_o(wr_ok), .ill_o(ill)
  );

  csr_rmw_bank #(
    .XLEN(XLEN), .NUM_CSR(NUM_CSR), .WMASK(WMASK), .RST_VAL(RST_VAL)
  ) i_bank (
    .clk_i(clk_i), .rst_i(rst_i), .we_i(wr_ok), .clr_i(clr), .sel_i(sel),
    .mask_i(mask), .rd_o(cur), .eff_o(eff)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rd_o     <= '0;
      rd_fx_o  <= 1'b0;
      wr_fx_o  <= 1'b0;
      fld_fx_o <= '0;
      ill_o    <= 1'b0;
    end else begin
      rd_o     <= rd_ok ? cur : '0;
      rd_fx_o  <= rd_ok;
      wr_fx_o  <= wr_ok;
      fld_fx_o <= wr_ok ? eff : '0;
      ill_o    <= ill;
    end
  end
endmodule

// File: rtl/csr_rmw_chk.sv
module csr_rmw_chk #(
  parameter int XLEN     = 32,
  parameter int NUM_CSR  = 4,
  parameter int ADDR_W   = 12,
  parameter int IDX_W    = 5,
  parameter int CSR_BASE = 12'h7C0
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              vld_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [IDX_W-1:0]  rs1_idx_i,
  input logic [XLEN-1:0]   rd_o,
  input logic              rd_fx_o,
  input logic              wr_fx_o,
  input logic [XLEN-1:0]   fld_fx_o,
  input logic              ill_o
);
  logic out_rng;
  assign out_rng = (int'(addr_i) < CSR_BASE) || (int'(addr_i) >= CSR_BASE + NUM_CSR);

  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    !vld_i |=> (!rd_fx_o && !wr_fx_o && !ill_o && fld_fx_o == '0));

  a_r6_zero_idx_no_write: assert property (@(posedge clk_i) disable iff (rst_i)
    (vld_i && rs1_idx_i == '0) |=> (!wr_fx_o && fld_fx_o == '0));

  a_r10_unknown_addr: assert property (@(posedge clk_i) disable iff (rst_i)
    (vld_i && out_rng) |=> (ill_o && rd_o == '0 && !rd_fx_o));

  a_r9_trap_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
    ill_o |-> (!rd_fx_o && !wr_fx_o && fld_fx_o == '0 && rd_o == '0));

  a_r8_fields_need_write: assert property (@(posedge clk_i) disable iff (rst_i)
    (fld_fx_o != '0) |-> wr_fx_o);

  a_r2_write_implies_read: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_fx_o |-> rd_fx_o);
endmodule

bind csr_rmw_unit csr_rmw_chk #(
  .XLEN(XLEN), .NUM_CSR(NUM_CSR), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CSR_BASE(CSR_BASE)
) i_chk (
  .clk_i(clk_i), .rst_i(rst_i), .vld_i(vld_i), .addr_i(addr_i),
  .rs1_idx_i(rs1_idx_i), .rd_o(rd_o), .rd_fx_o(rd_fx_o), .wr_fx_o(wr_fx_o),
  .fld_fx_o(fld_fx_o), .ill_o(ill_o)
);

// File: tb/test_csr_rmw_unit.sv
`timescale 1ns/1ps
module test_csr_rmw_unit;
  localparam int BASE = 12'h7C0;
  localparam logic [31:0] WM  [4] = '{32'hFFFF_FFFF, 32'hF0F0_F0F0, 32'h0000_00FF, 32'hFFFF_FFFF};
  localparam logic [31:0] RV  [4] = '{32'h1234_5678, 32'h0000_0000, 32'h0000_0030, 32'hA5A5_0001};
  localparam logic        RO  [4] = '{1'b0, 1'b0, 1'b0, 1'b1};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vld = 1'b0;
  logic [1:0]  op  = '0;
  logic [11:0] addr = '0;
  logic [4:0]  idx = '0;
  logic [31:0] val = '0;
  logic [31:0] rd_o, fld_fx_o;
  logic        rd_fx_o, wr_fx_o, ill_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [31:0] model [4];

  always #5 clk = ~clk;

  csr_rmw_unit i_csr_rmw_unit (
    .clk_i(clk), .rst_i(rst), .vld_i(vld), .op_i(op), .addr_i(addr),
    .rs1_idx_i(idx), .rs1_val_i(val), .rd_o(rd_o), .rd_fx_o(rd_fx_o),
    .wr_fx_o(wr_fx_o), .fld_fx_o(fld_fx_o), .ill_o(ill_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad = n_bad + 1;
      n_chk = n_chk + 1;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic chk(string tag, logic [67:0] act, logic [67:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Issue one operation and compare the next-cycle outputs with the model.
  task automatic do_op(string tag, logic [1:0] o, logic [11:0] a, logic [4:0] ix, logic [31:0] v);
    logic hit, wa;
    int s;
    logic [31:0] m, e_rd, e_fld;
    logic e_rfx, e_wfx, e_ill;
    @(negedge clk);
    vld = 1'b1; op = o; addr = a; idx = ix; val = v;
    s   = int'(a) - BASE;
    hit = (s >= 0) && (s < 4);
    wa  = (ix != 0);
    m   = o[1] ? {27'd0, ix} : v;
    e_rd = '0; e_fld = '0; e_rfx = 0; e_wfx = 0; e_ill = 0;
    if (!hit || (wa && RO[s])) e_ill = 1;
    else begin
      e_rd = model[s]; e_rfx = 1; e_wfx = wa;
      if (wa) begin
        e_fld = m & WM[s];
        model[s] = o[0] ? (model[s] & ~e_fld) : (model[s] | e_fld);
      end
    end
    @(posedge clk); #1;
    chk(tag, {1'b0, ill_o, wr_fx_o, rd_fx_o, rd_o, fld_fx_o},
             {1'b0, e_ill, e_wfx, e_rfx, e_rd, e_fld});
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    vld = 1'b0;
    @(posedge clk); #1;
    chk(tag, {1'b0, ill_o, wr_fx_o, rd_fx_o, rd_o, fld_fx_o}, '0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 4; k++) model[k] = RV[k];
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs zero during reset
    chk("R1 reset outputs", {1'b0, ill_o, wr_fx_o, rd_fx_o, rd_o, fld_fx_o}, '0);
    @(negedge clk); rst = 1'b0;
    // R1/R2: reset values read back with index zero
    for (int k = 0; k < 4; k++) do_op("R1 reset value", 2'b00, 12'(BASE + k), 5'd0, 32'hFFFF_FFFF);
    // R3: register set, masked by writable bits
    do_op("R3 set reg2", 2'b00, 12'(BASE + 2), 5'd7, 32'h0000_FF0F);
    do_op("R11 back-to-back read", 2'b00, 12'(BASE + 2), 5'd0, 32'h0);
    do_op("R3 set reg1", 2'b00, 12'(BASE + 1), 5'd3, 32'hFFFF_FFFF);
    // R4: register clear
    do_op("R4 clear reg1", 2'b01, 12'(BASE + 1), 5'd9, 32'h00FF_00FF);
    do_op("R4 readback", 2'b00, 12'(BASE + 1), 5'd0, 32'h0);
    // R5: immediate forms ignore rs1_val_i
    do_op("R5 clri reg0", 2'b11, 12'(BASE + 0), 5'h18, 32'hFFFF_FFFF);
    do_op("R5 seti reg0", 2'b10, 12'(BASE + 0), 5'h01, 32'hFFFF_0000);
    do_op("R5 readback", 2'b10, 12'(BASE + 0), 5'h00, 32'hFFFF_FFFF);
    // R6: index zero on read-only register is a legal read
    do_op("R6 ro read", 2'b01, 12'(BASE + 3), 5'd0, 32'hFFFF_FFFF);
    // R7: nonzero index, zero operand
    do_op("R7 zero operand", 2'b01, 12'(BASE + 0), 5'd4, 32'h0);
    // R9: write attempt to read-only register
    do_op("R9 ro write", 2'b00, 12'(BASE + 3), 5'd2, 32'h0000_0F00);
    do_op("R9 ro unchanged", 2'b00, 12'(BASE + 3), 5'd0, 32'h0);
    do_op("R9 ro imm write", 2'b11, 12'(BASE + 3), 5'd1, 32'h0);
    // R10: addresses just outside the bank
    do_op("R10 below", 2'b00, 12'(BASE - 1), 5'd0, 32'h0);
    do_op("R10 above", 2'b01, 12'(BASE + 4), 5'd5, 32'h1);
    // R12: idle cycle
    idle("R12 idle");
    // R8/R11: random mix
    for (int n = 0; n < 400; n++) begin
      logic [1:0]  ro_;
      logic [11:0] ra;
      logic [4:0]  ri;
      logic [31:0] rv;
      ro_ = 2'($urandom_range(0, 3));
      ra  = 12'(BASE - 1 + $urandom_range(0, 5));
      ri  = ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom);
      rv  = ($urandom_range(0, 5) == 0) ? 32'd0 : $urandom;
      if ($urandom_range(0, 9) == 0) idle("R12 random idle");
      else do_op("R8 R11 random", ro_, ra, ri, rv);
    end
    // R1: reset mid-run restores values
    @(negedge clk); vld = 1'b0; rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 4; k++) model[k] = RV[k];
    for (int k = 0; k < 4; k++) do_op("R1 re-reset", 2'b00, 12'(BASE + k), 5'd0, 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule